// File: doc/BRIEF.md
# Registered Sklansky Prefix Adder

This block adds two unsigned operands without a carry-in and returns the sum together with a carry-out. The carries come from a Sklansky parallel prefix tree. Each bit first yields a generate term (both operand bits high) and a propagate term (operand bits differ). The tree then merges those terms over log2(W) levels. At each level the group size doubles, and the upper half of every block takes the single group term at the top of the lower half. Where a span reaches bit 0, a cell that computes only the generate term is used. Everywhere else a cell that computes both generate and propagate is used. The tree is built from explicit cell instances, not from an arithmetic operator.

The arithmetic core holds no state. A thin wrapper registers the operands on the way in and the results on the way out, so the core sits between two register stages. The core's group generate vector is brought out as a named wire, so its carry meaning can be checked on its own.

Top module: `spx_adder_top`

## Requirements
- R1: Operands presented before a rising clock edge appear as sum and carry-out after the second rising edge, giving a latency of two cycles.
- R2: The 17-bit value {cout, sum} equals the unsigned value a + b for every operand pair.
- R3: sum[0] equals a[0] XOR b[0]. The lowest sum bit never depends on any carry.
- R4: For every bit position i, the group generate term for span i:0 equals the carry out of bits i:0 of a + b.
- R5: 0x7FFF + 0x0001 gives sum 0x8000 and carry-out 0. The generate at bit 0 travels the full tree to bit 15.
- R6: 0xFFFF + 0x0001 gives sum 0x0000 and carry-out 1.
- R7: Each of 0x3FFF, 0x1FFF, 0x0FFF, 0x07FF and 0x03FF plus 0x0001 gives the next power of two, with carry-out 0.
- R8: 0x0000 + 0x0000 gives 0x0000 with carry-out 0. 0xFFFF + 0xFFFF gives 0xFFFE with carry-out 1.
- R9: While rst_n is low, sum and carry-out read 0. Both stay 0 on the first edge after release, because the operand register was cleared.
- R10: There is no carry-in. An all-propagate input such as 0xFFFF + 0x0000 gives 0xFFFF with carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | W (16) | First operand |
| b | input | W (16) | Second operand |
| sum | output | W (16) | Registered sum |
| cout | output | 1 | Registered carry-out |

## Verification
The bench builds the block only with the default width W = 16, which gives a four-level tree. At this width every level sees patterns that stress it. The long carry vectors force a generate through grey cells at all four levels. The all-ones and zero corners test the black cells where the group propagate stays high or low. Random pairs, many of them biased towards long runs of ones, cover the remaining cell pairings. A reference that adds one bit at a time is compared against every result.

// File: rtl/spx_pkg.sv
package spx_pkg;

  // Generate half of a prefix merge: upper span wins or passes lower generate
  function automatic logic merge_g(input logic g_hi, input logic p_hi, input logic g_lo);
    return g_hi | (p_hi & g_lo);
  endfunction

  // Propagate half of a prefix merge
  function automatic logic merge_p(input logic p_hi, input logic p_lo);
    return p_hi & p_lo;
  endfunction

  // Number of prefix levels for a given width
  function automatic int tree_depth(input int width);
    return (width <= 1) ? 1 : $clog2(width);
  endfunction

endpackage

// File: rtl/spx_pg_gen.sv
module spx_pg_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] bit_g,
  output logic [W-1:0] bit_p
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_g[i] = op_a[i] & op_b[i];
    assign bit_p[i] = op_a[i] ^ op_b[i];
  end
endmodule

// File: rtl/spx_prefix_cell.sv
module spx_prefix_cell #(
  parameter bit FULL = 1'b1   // 1: generate+propagate cell, 0: generate-only cell
) (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);
  import spx_pkg::*;

  assign g_out = merge_g(g_hi, p_hi, g_lo);

  if (FULL) begin : g_full
    assign p_out = merge_p(p_hi, p_lo);
  end else begin : g_gonly
    logic unused_plo;
    assign unused_plo = p_lo;
    assign p_out      = 1'b0;
  end
endmodule

// File: rtl/spx_prefix_net.sv
module spx_prefix_net #(
  parameter int W = 16
) (
  input  logic [W-1:0] bit_g,
  input  logic [W-1:0] bit_p,
  output logic [W-1:0] grp_g
);
  localparam int LV = spx_pkg::tree_depth(W);

  logic [LV:0][W-1:0] g_l;
  logic [LV:0][W-1:0] p_l;

  assign g_l[0] = bit_g;
  assign p_l[0] = bit_p;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_pos
      if (((i >> l) & 1) == 1) begin : g_join
        // source: top bit of the adjacent lower half-block
        localparam int SRC = ((i >> l) << l) - 1;
        localparam bit REACH0 = ((i >> (l + 1)) == 0);
        spx_prefix_cell #(.FULL(!REACH0)) u_cell (
          .g_hi (g_l[l][i]),
          .p_hi (p_l[l][i]),
          .g_lo (g_l[l][SRC]),
          .p_lo (p_l[l][SRC]),
          .g_out(g_l[l+1][i]),
          .p_out(p_l[l+1][i])
        );
      end else begin : g_pass
        assign g_l[l+1][i] = g_l[l][i];
        assign p_l[l+1][i] = p_l[l][i];
      end
    end
  end

  logic unused_p_tail;
  assign unused_p_tail = ^p_l[LV];

  assign grp_g = g_l[LV];
endmodule

// File: rtl/spx_sum_form.sv
module spx_sum_form #(
  parameter int W = 16
) (
  input  logic [W-1:0] bit_p,
  input  logic [W-1:0] grp_g,
  output logic [W-1:0] sum_c,
  output logic         cout_c
);
  assign sum_c[0] = bit_p[0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum_c[i] = bit_p[i] ^ grp_g[i-1];
  end
  assign cout_c = grp_g[W-1];
endmodule

// File: rtl/spx_adder_top.sv
module spx_adder_top #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int WX = W + 1;

  // Carry out of every span i:0, derived from whole-word arithmetic
  function automatic logic [W-1:0] carry_vec(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [WX-1:0] tot;
    logic [WX-1:0] flips;
    tot   = {1'b0, x} + {1'b0, y};
    flips = tot ^ {1'b0, x} ^ {1'b0, y};
    return flips[WX-1:1];
  endfunction

  logic [W-1:0] a_q, b_q;
  logic [W-1:0] bit_g, bit_p, grp_g;
  logic [W-1:0] sum_c;
  logic         cout_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a;
      b_q <= b;
    end
  end

  spx_pg_gen #(.W(W)) u_pg (
    .op_a (a_q),
    .op_b (b_q),
    .bit_g(bit_g),
    .bit_p(bit_p)
  );

  spx_prefix_net #(.W(W)) u_tree (
    .bit_g(bit_g),
    .bit_p(bit_p),
    .grp_g(grp_g)
  );

  spx_sum_form #(.W(W)) u_sum (
    .bit_p (bit_p),
    .grp_g (grp_g),
    .sum_c (sum_c),
    .cout_c(cout_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_c;
      cout <= cout_c;
    end
  end

  // R2: registered result equals whole-word addition of the operands held one cycle earlier
  p_sum_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    {cout, sum} == $past({1'b0, a_q} + {1'b0, b_q}));

  // R4: group generate vector of the tree matches the carries of the held operands
  p_group_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grp_g == carry_vec(a_q, b_q));

  // R3: lowest sum bit is the operand bits exclusive-or
  p_low_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sum[0] == $past(a_q[0] ^ b_q[0]));

  // R9: outputs are clear after any cycle spent in reset
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(!rst_n) |-> (sum == '0 && cout == 1'b0));
endmodule

// File: tb/spx_adder_top_tb.sv
module spx_adder_top_tb;
  localparam int W       = 16;
  localparam int CLK_PER = 10;
  localparam int N_RAND  = 3000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] sum;
  logic         cout;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  spx_adder_top #(.W(W)) u_dut (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (a),
    .b    (b),
    .sum  (sum),
    .cout (cout)
  );

  // Bit-serial reference: full adder stepped from bit 0 upward
  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] r;
    logic c;
    c = 1'b0;
    for (int k = 0; k < W; k++) begin
      r[k] = x[k] ^ y[k] ^ c;
      c    = (x[k] & y[k]) | (c & (x[k] ^ y[k]));
    end
    r[W] = c;
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // R1: drive at falling edge, two rising edges, sample at following falling edge
  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(req, {cout, sum}, ref_add(x, y));
  endtask

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'd5323));

    // R9: reset state, then first edge after release
    a = 16'hABCD;
    b = 16'h1234;
    #(CLK_PER * 3);
    check("R9 reset", {cout, sum}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R9 first edge", {cout, sum}, '0);

    // R1: one edge after presentation the new result is not yet visible
    @(negedge clk);
    a = 16'h0001;
    b = 16'h0002;
    @(posedge clk);
    @(negedge clk);
    check("R1 early", {cout, sum}, ref_add(16'hABCD, 16'h1234));
    @(posedge clk);
    @(negedge clk);
    check("R1 latency", {cout, sum}, 17'h00003);

    apply("R5 7FFF+1", 16'h7FFF, 16'h0001);
    check("R5 value", {cout, sum}, 17'h08000);
    apply("R6 FFFF+1", 16'hFFFF, 16'h0001);
    check("R6 value", {cout, sum}, 17'h10000);
    apply("R7 3FFF+1", 16'h3FFF, 16'h0001);
    apply("R7 1FFF+1", 16'h1FFF, 16'h0001);
    apply("R7 0FFF+1", 16'h0FFF, 16'h0001);
    apply("R7 07FF+1", 16'h07FF, 16'h0001);
    apply("R7 03FF+1", 16'h03FF, 16'h0001);
    check("R7 value", {cout, sum}, 17'h00400);
    apply("R8 0+0", 16'h0000, 16'h0000);
    check("R8 zero", {cout, sum}, 17'h00000);
    apply("R8 FFFF+FFFF", 16'hFFFF, 16'hFFFF);
    check("R8 ones", {cout, sum}, 17'h1FFFE);
    apply("R10 FFFF+0", 16'hFFFF, 16'h0000);
    check("R10 no cin", {cout, sum}, 17'h0FFFF);
    apply("R10 0+FFFF", 16'h0000, 16'hFFFF);
    apply("R3 low bit", 16'h0001, 16'h0000);
    check("R3 value", {cout, sum}, 17'h00001);

    // R2 R4: random pairs, some biased to long ones runs
    for (int n = 0; n < N_RAND; n++) begin
      int mode;
      mode = int'($urandom % 4);
      ra = W'($urandom);
      rb = W'($urandom);
      if (mode == 1) ra = W'((32'h1 << ($urandom % W)) - 1);
      if (mode == 2) rb = ~ra ^ W'(32'h1 << ($urandom % W));
      apply("R2 R4 random", ra, rb);
    end

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule